// File: doc/BRIEF.md
# Per-Thread Resource Stall Tracker

This block records, separately for each hardware thread, which resource requests currently hold a pipeline stage back. Each record is a key made of three fields: a resource identifier, an instruction sequence number and a slot index. A resource that cannot serve a request raises a set-stall for the thread with that key. When the request is later served, the resource raises a clear-stall with the same key.

A thread counts as stalled by resources whenever its table holds at least one record. The stage's control logic combines this flag with its other stall sources. A per-thread flush input drops every record of one thread in a single cycle. Control logic uses it when it discards a thread's stall state, for example on a takeover.

Each thread's table is an ordered list. A set-stall appends a record at the tail. A clear-stall removes only the oldest record whose three fields all equal the request. Two narrow event outputs are also provided. One marks a set-stall dropped because the table was full. The other marks the cycle in which a thread's table has just become empty.

Top module: `stall_tracker`

## Requirements
- R1: A set-stall (`set_valid` high) appends one record holding `set_res`, `set_seq` and `set_slot` to the table of thread `set_thread`. That thread's `stalled` bit is high from the next cycle on.
- R2: A clear-stall (`clr_valid` high) removes only the oldest record of thread `clr_thread` whose resource, sequence number and slot all equal the request. Any other records with the same key stay in the table.
- R3: A clear-stall whose key matches no record leaves the table unchanged. This includes a key that differs in one field only, and a clear-stall on an empty table.
- R4: Bit t of `stalled` is high exactly when thread t's table holds one or more records. Threads are independent of each other.
- R5: A high bit t of `flush` empties thread t's table at the next clock edge. A set-stall to that thread in the same cycle is discarded, and `overflow` is not raised for it.
- R6: A set-stall to a thread whose table holds DEPTH records after the same-cycle clear is dropped. Bit t of `overflow` is then high for exactly the following cycle.
- R7: When a set-stall and a clear-stall address the same thread in one cycle, the clear is applied to the existing records first and the append follows. A full table with a matching clear therefore accepts the new record. A clear that carries the same key as the new record misses.
- R8: Bit t of `drained` is high for exactly one cycle, namely the first cycle in which thread t's table is empty after holding records.
- R9: While `rst_n` is low, every table is empty and `stalled`, `overflow` and `drained` are all zero. The reset is asynchronous.
- R10: A clear-stall addressed to one thread never removes a record of another thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_valid | input | 1 | Set-stall request strobe |
| set_thread | input | TID_W | Thread addressed by the set-stall |
| set_res | input | RES_W | Resource identifier of the new record |
| set_seq | input | SEQ_W | Instruction sequence number of the new record |
| set_slot | input | SLOT_W | Slot index of the new record |
| clr_valid | input | 1 | Clear-stall request strobe |
| clr_thread | input | TID_W | Thread addressed by the clear-stall |
| clr_res | input | RES_W | Resource identifier to match |
| clr_seq | input | SEQ_W | Instruction sequence number to match |
| clr_slot | input | SLOT_W | Slot index to match |
| flush | input | NUM_THREADS | Per-thread request to empty the table |
| stalled | output | NUM_THREADS | Per-thread table-not-empty flag |
| overflow | output | NUM_THREADS | One-cycle pulse after a dropped set-stall |
| drained | output | NUM_THREADS | One-cycle pulse when a table has just become empty |

## Verification
The bench builds the tracker with NUM_THREADS=2 and DEPTH=3. With a depth of three, a thread's table fills in three set-stalls, so the overflow path and the full-table case of a same-cycle clear and set are both exercised within a few vectors. Two threads are enough to show that clears and flushes touch only the addressed thread, and that each thread's stalled and drained bits move on their own. Duplicate keys and keys that differ only in the slot field are used to show that a clear removes only the oldest exact match.

// File: rtl/stall_trk_pkg.sv
package stall_trk_pkg;

  // Field widths of one stall record.
  localparam int RES_W  = 4;
  localparam int SEQ_W  = 8;
  localparam int SLOT_W = 2;

  typedef struct packed {
    logic [RES_W-1:0]  res;
    logic [SEQ_W-1:0]  seq;
    logic [SLOT_W-1:0] slot;
  } stall_key_t;

  // A record matches a clear request only when all three fields agree.
  function automatic logic key_equal(input stall_key_t a, input stall_key_t b);
    return (a.res == b.res) && (a.seq == b.seq) && (a.slot == b.slot);
  endfunction

  function automatic stall_key_t make_key(input logic [RES_W-1:0] r,
                                          input logic [SEQ_W-1:0] s,
                                          input logic [SLOT_W-1:0] sl);
    stall_key_t k;
    k.res  = r;
    k.seq  = s;
    k.slot = sl;
    return k;
  endfunction

endpackage

// File: rtl/stall_first_hit.sv
module stall_first_hit #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     hits,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  // Lowest set bit wins: the oldest record sits at the lowest position.
  always_comb begin
    found = |hits;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/stall_thread_table.sv
module stall_thread_table
  import stall_trk_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_en,
  input  stall_key_t set_key,
  input  logic       clr_en,
  input  stall_key_t clr_key,
  input  logic       flush,
  output logic       stalled_o,
  output logic       ovf_o,
  output logic       drained_o
);

  stall_key_t tab_q   [DEPTH];
  stall_key_t shifted [DEPTH];
  stall_key_t tab_mid [DEPTH];
  stall_key_t tab_d   [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_mid, cnt_d;
  logic ovf_q, drained_q;

  // Named internal events
  logic [DEPTH-1:0] clr_hits;
  logic             clr_found;
  logic [IDX_W-1:0] clr_idx;
  logic             set_accept;
  logic             set_drop;
  logic             going_empty;

  // Records one place further down the list, used to close the gap.
  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_shift
      if (g < DEPTH - 1) begin : g_mid
        assign shifted[g] = tab_q[g+1];
      end else begin : g_last
        assign shifted[g] = '0;
      end
      assign clr_hits[g] = clr_en && (CNT_W'(g) < cnt_q) && key_equal(tab_q[g], clr_key);
    end
  endgenerate

  stall_first_hit #(.N(DEPTH)) u_first (
    .hits  (clr_hits),
    .found (clr_found),
    .idx   (clr_idx)
  );

  // Clear first, then append, then flush overrides everything.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (clr_found && (IDX_W'(i) >= clr_idx)) tab_mid[i] = shifted[i];
      else                                     tab_mid[i] = tab_q[i];
    end
    cnt_mid    = cnt_q - CNT_W'(clr_found);
    set_accept = set_en && !flush && (cnt_mid < CNT_W'(DEPTH));
    set_drop   = set_en && !flush && !set_accept;
    for (int i = 0; i < DEPTH; i++) begin
      if (set_accept && (CNT_W'(i) == cnt_mid)) tab_d[i] = set_key;
      else                                      tab_d[i] = tab_mid[i];
    end
    if (flush) cnt_d = '0;
    else       cnt_d = cnt_mid + CNT_W'(set_accept);
    going_empty = (cnt_q != '0) && (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tab_q[i] <= '0;
      cnt_q     <= '0;
      ovf_q     <= 1'b0;
      drained_q <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) tab_q[i] <= tab_d[i];
      cnt_q     <= cnt_d;
      ovf_q     <= set_drop;
      drained_q <= going_empty;
    end
  end

  assign stalled_o = (cnt_q != '0);
  assign ovf_o     = ovf_q;
  assign drained_o = drained_q;

  // Checks next to the logic they guard
  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));

  assert_full_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !flush && (cnt_q == CNT_W'(DEPTH)) && !clr_found) |=> ovf_q);

  assert_ovf_needs_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && (cnt_q < CNT_W'(DEPTH))) |=> !ovf_q);

  assert_miss_keeps_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !clr_found && !set_en && !flush) |=> $stable(cnt_q));

  assert_hit_removes_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_found && !set_en && !flush) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_drain_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drained_q |-> (!stalled_o && $past(cnt_q) != '0));

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/stall_tracker.sv
module stall_tracker
  import stall_trk_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int DEPTH       = 4,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_valid,
  input  logic [TID_W-1:0]       set_thread,
  input  logic [RES_W-1:0]       set_res,
  input  logic [SEQ_W-1:0]       set_seq,
  input  logic [SLOT_W-1:0]      set_slot,
  input  logic                   clr_valid,
  input  logic [TID_W-1:0]       clr_thread,
  input  logic [RES_W-1:0]       clr_res,
  input  logic [SEQ_W-1:0]       clr_seq,
  input  logic [SLOT_W-1:0]      clr_slot,
  input  logic [NUM_THREADS-1:0] flush,
  output logic [NUM_THREADS-1:0] stalled,
  output logic [NUM_THREADS-1:0] overflow,
  output logic [NUM_THREADS-1:0] drained
);

  stall_key_t set_key, clr_key;
  logic [NUM_THREADS-1:0] set_sel, clr_sel;

  assign set_key = make_key(set_res, set_seq, set_slot);
  assign clr_key = make_key(clr_res, clr_seq, clr_slot);

  genvar t;
  generate
    for (t = 0; t < NUM_THREADS; t++) begin : g_thr
      // R10: each table only sees requests addressed to its own thread
      assign set_sel[t] = set_valid && (set_thread == TID_W'(t));
      assign clr_sel[t] = clr_valid && (clr_thread == TID_W'(t));

      stall_thread_table #(.DEPTH(DEPTH)) u_tab (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (set_sel[t]),
        .set_key   (set_key),
        .clr_en    (clr_sel[t]),
        .clr_key   (clr_key),
        .flush     (flush[t]),
        .stalled_o (stalled[t]),
        .ovf_o     (overflow[t]),
        .drained_o (drained[t])
      );
    end
  endgenerate

  assert_one_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_sel) && $onehot0(set_sel));

endmodule

// File: tb/tb_stall_tracker.sv
module tb_stall_tracker;
  import stall_trk_pkg::*;

  localparam int NT = 2;
  localparam int DP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_valid = 1'b0, clr_valid = 1'b0;
  logic [0:0] set_thread = '0, clr_thread = '0;
  logic [RES_W-1:0] set_res = '0, clr_res = '0;
  logic [SEQ_W-1:0] set_seq = '0, clr_seq = '0;
  logic [SLOT_W-1:0] set_slot = '0, clr_slot = '0;
  logic [NT-1:0] flush = '0;
  logic [NT-1:0] stalled, overflow, drained;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stall_tracker #(.NUM_THREADS(NT), .DEPTH(DP)) dut (
    .clk, .rst_n, .set_valid, .set_thread, .set_res, .set_seq, .set_slot,
    .clr_valid, .clr_thread, .clr_res, .clr_seq, .clr_slot, .flush,
    .stalled, .overflow, .drained
  );

  // Keys: 0=A(1,10,0) 1=B(2,11,1) 2=C(3,12,2) 3=A with slot 1 (partial match of A)
  function automatic stall_key_t key_of(input logic [1:0] k);
    case (k)
      2'd0:    return make_key(4'd1, 8'd10, 2'd0);
      2'd1:    return make_key(4'd2, 8'd11, 2'd1);
      2'd2:    return make_key(4'd3, 8'd12, 2'd2);
      default: return make_key(4'd1, 8'd10, 2'd1);
    endcase
  endfunction

  typedef struct packed {
    logic sv; logic st; logic [1:0] sk;
    logic cv; logic ct; logic [1:0] ck;
    logic [1:0] fl; logic [1:0] es; logic [1:0] eo; logic [1:0] ed;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,2'd0, 1'b0,1'b0,2'd0, 2'b00, 2'b01,2'b00,2'b00, 4'd1},  // R1 set T0 A
    '{1'b1,1'b0,2'd0, 1'b0,1'b0,2'd0, 2'b00, 2'b01,2'b00,2'b00, 4'd1},  // R1 duplicate A
    '{1'b0,1'b0,2'd0, 1'b1,1'b0,2'd0, 2'b00, 2'b01,2'b00,2'b00, 4'd2},  // R2 one A left
    '{1'b0,1'b0,2'd0, 1'b1,1'b0,2'd3, 2'b00, 2'b01,2'b00,2'b00, 4'd3},  // R3 slot differs
    '{1'b0,1'b0,2'd0, 1'b1,1'b1,2'd0, 2'b00, 2'b01,2'b00,2'b00, 4'd10}, // R10 other thread
    '{1'b0,1'b0,2'd0, 1'b1,1'b0,2'd0, 2'b00, 2'b00,2'b00,2'b01, 4'd8},  // R8 last A gone
    '{1'b0,1'b0,2'd0, 1'b0,1'b0,2'd0, 2'b00, 2'b00,2'b00,2'b00, 4'd8},  // R8 pulse ends
    '{1'b1,1'b0,2'd0, 1'b0,1'b0,2'd0, 2'b00, 2'b01,2'b00,2'b00, 4'd1},  // R1 A
    '{1'b1,1'b0,2'd1, 1'b0,1'b0,2'd0, 2'b00, 2'b01,2'b00,2'b00, 4'd1},  // R1 B
    '{1'b1,1'b0,2'd2, 1'b0,1'b0,2'd0, 2'b00, 2'b01,2'b00,2'b00, 4'd4},  // R4 C, full
    '{1'b1,1'b0,2'd0, 1'b0,1'b0,2'd0, 2'b00, 2'b01,2'b01,2'b00, 4'd6},  // R6 dropped
    '{1'b0,1'b0,2'd0, 1'b0,1'b0,2'd0, 2'b00, 2'b01,2'b00,2'b00, 4'd6},  // R6 pulse ends
    '{1'b1,1'b0,2'd0, 1'b1,1'b0,2'd1, 2'b00, 2'b01,2'b00,2'b00, 4'd7},  // R7 full, clr B + set A
    '{1'b1,1'b1,2'd1, 1'b0,1'b0,2'd0, 2'b00, 2'b11,2'b00,2'b00, 4'd4},  // R4 T1 B
    '{1'b0,1'b0,2'd0, 1'b1,1'b0,2'd2, 2'b00, 2'b11,2'b00,2'b00, 4'd2},  // R2 clr C
    '{1'b0,1'b0,2'd0, 1'b1,1'b0,2'd0, 2'b00, 2'b11,2'b00,2'b00, 4'd2},  // R2 clr A
    '{1'b0,1'b0,2'd0, 1'b1,1'b0,2'd0, 2'b00, 2'b10,2'b00,2'b01, 4'd8},  // R8 T0 empty
    '{1'b1,1'b1,2'd2, 1'b1,1'b1,2'd2, 2'b00, 2'b10,2'b00,2'b00, 4'd7},  // R7 clr misses new C
    '{1'b1,1'b1,2'd0, 1'b0,1'b0,2'd0, 2'b10, 2'b00,2'b00,2'b10, 4'd5},  // R5 flush beats set
    '{1'b1,1'b0,2'd0, 1'b1,1'b0,2'd0, 2'b00, 2'b01,2'b00,2'b00, 4'd7},  // R7 empty: clr then set
    '{1'b0,1'b0,2'd0, 1'b0,1'b0,2'd0, 2'b01, 2'b00,2'b00,2'b01, 4'd5},  // R5 flush T0
    '{1'b1,1'b1,2'd0, 1'b0,1'b0,2'd0, 2'b01, 2'b10,2'b00,2'b00, 4'd5},  // R5 flush empty T0
    '{1'b0,1'b0,2'd0, 1'b1,1'b1,2'd0, 2'b00, 2'b00,2'b00,2'b10, 4'd8},  // R8 T1 empty
    '{1'b0,1'b0,2'd0, 1'b1,1'b0,2'd0, 2'b00, 2'b00,2'b00,2'b00, 4'd3}   // R3 clr on empty
  };

  task automatic check(input string req, input string what,
                       input logic [NT-1:0] act, input logic [NT-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic drive_idle();
    set_valid = 1'b0;
    clr_valid = 1'b0;
    flush     = '0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    stall_key_t sk, ck;
    drive_idle();
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9", "stalled in reset", stalled, '0);
    check("R9", "overflow in reset", overflow, '0);
    check("R9", "drained in reset", drained, '0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      sk = key_of(VECS[v].sk);
      ck = key_of(VECS[v].ck);
      set_valid  = VECS[v].sv;
      set_thread = VECS[v].st;
      set_res = sk.res; set_seq = sk.seq; set_slot = sk.slot;
      clr_valid  = VECS[v].cv;
      clr_thread = VECS[v].ct;
      clr_res = ck.res; clr_seq = ck.seq; clr_slot = ck.slot;
      flush = VECS[v].fl;
      @(posedge clk);
      #1;
      check($sformatf("R%0d", VECS[v].rq), $sformatf("vec%0d stalled", v), stalled, VECS[v].es);
      check($sformatf("R%0d", VECS[v].rq), $sformatf("vec%0d overflow", v), overflow, VECS[v].eo);
      check($sformatf("R%0d", VECS[v].rq), $sformatf("vec%0d drained", v), drained, VECS[v].ed);
    end

    // R9: asynchronous reset mid-run clears a populated table
    @(negedge clk);
    drive_idle();
    sk = key_of(2'd1);
    set_valid = 1'b1; set_thread = 1'b1;
    set_res = sk.res; set_seq = sk.seq; set_slot = sk.slot;
    @(posedge clk);
    #1;
    check("R1", "T1 set before reset", stalled, 2'b10);
    drive_idle();
    #2;
    rst_n = 1'b0;
    #1;
    check("R9", "stalled after async reset", stalled, '0);
    check("R9", "drained after async reset", drained, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R9", "stalled after release", stalled, '0);

    done = 1'b1;
    finish_run();
  end

endmodule